// File: doc/BRIEF.md
# CPU and DMA Display-Bus Slot Arbiter with Phase-Aligned Acknowledge

This block sits between a processor bus and a shared display-memory bus. The display bus is divided into time slots of two fast-clock cycles each. The processor runs on the fast clock, which is phase-locked to the slot clock at twice its rate. The block keeps track of which half of the slot is current. At the close of each slot it gives the next slot either to the DMA engine or to a waiting processor access. It holds off the processor's data acknowledge so that the acknowledge always appears in the second half of a slot, whatever phase the access started in.

During every owned slot the block drives the dynamic-RAM row strobe, column strobe and write enable. The pattern depends on whether the slot carries a processor read, a processor write or a DMA transfer. In a DMA slot the block places the DMA engine's cycle code on a register-code bus for the peripheral chips. Outside DMA slots that bus carries an all-ones idle code.

Accesses outside display memory never use a display slot. They are acknowledged at the next phase point, so they can run alongside DMA traffic. The display-side data drivers are enabled only for slots owned by the processor.

Top module: `disp_slot_arb`

## Requirements
- R1: `slot_phase` is 0 in the first cycle after reset and inverts on every rising clock edge after that. A cycle with `slot_phase`=0 is the first half of a slot, and a cycle with `slot_phase`=1 is the second half.
- R2: `cpu_dtack_n` only ever goes low at the edge that closes a first-half cycle. It is therefore first seen low in a cycle with `slot_phase`=1.
- R3: Slot ownership is decided at the edge that closes a second-half cycle and is held for both cycles of the slot. If `dma_req` is 1 at that edge, the DMA engine gets the slot (`grant_dma`=1), even when a processor request is waiting.
- R4: A display access (`cpu_addr` < 0x200000, `cpu_as_n`=0) with no competing DMA is granted the next slot and acknowledged at that slot's midpoint. Counted in cycles after the cycle in which the strobe is first driven low, the acknowledge appears 2 cycles later if that cycle has `slot_phase`=1 and 3 cycles later if it has `slot_phase`=0.
- R5: An access with `cpu_addr` >= 0x200000 is never given a display slot. It is acknowledged at the next edge that closes a first-half cycle, whatever the DMA traffic: 1 cycle later if the strobe is driven low in a cycle with `slot_phase`=0, and 2 cycles later if it has `slot_phase`=1.
- R6: `cpu_dtack_n` returns high on the first edge at which `cpu_as_n` is sampled high. After an acknowledge, holding `cpu_as_n` low causes no further grant or acknowledge until `cpu_as_n` has been sampled high at an edge.
- R7: In an owned slot, `ras_n` is low for both cycles and `cas_n` is low only in the second cycle. `we_n` is low for both cycles when the slot is a processor write (`cpu_rw`=0) or a DMA slot with `dma_wr`=1, and high otherwise. All three are high in idle slots.
- R8: During a DMA slot, `reg_code` holds the `dma_code` sampled at the arbitration edge. At all other times it holds the all-ones idle code.
- R9: `disp_drv_en` is 1 exactly during slots owned by the processor and is never 1 in the same cycle as `grant_dma`.
- R10: While `rst_n` is low, the outputs are as follows: `cpu_dtack_n`, `ras_n`, `cas_n` and `we_n` are 1; `grant_cpu`, `grant_dma`, `disp_drv_en` and `slot_phase` are 0; `reg_code` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (processor) clock, twice the slot rate |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 24 | Processor address; below 0x200000 is display memory |
| dma_req | input | 1 | DMA engine wants the next slot |
| dma_wr | input | 1 | Requested DMA slot writes memory |
| dma_code | input | 8 | Cycle code the DMA engine wants shown to peripherals |
| cpu_dtack_n | output | 1 | Processor data acknowledge, active low |
| slot_phase | output | 1 | 0 = first half of slot, 1 = second half |
| grant_cpu | output | 1 | Current slot belongs to the processor |
| grant_dma | output | 1 | Current slot belongs to the DMA engine |
| reg_code | output | 8 | Register-code bus; all ones when idle |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| disp_drv_en | output | 1 | Enable for the display-side data drivers |

## Verification
Display reads and writes are started in each slot half on an idle bus. Each one must be acknowledged after exactly 2 or 3 cycles, which shows that the stretch depends on the starting phase. Display and non-display accesses are then run against a DMA burst: the display access must wait out the burst, while the non-display access keeps its short latency. A run of slots with pseudo-random DMA requests, mixed with processor accesses that hold the strobe low after the acknowledge, exercises arbitration at every slot boundary. On every cycle the bench checks each output against a behavioural model, and it separately checks the phase of every acknowledge edge and that the processor and the DMA engine never drive the display bus together.

// File: rtl/disp_arb_pkg.sv
package disp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2
  } owner_e;
endpackage

// File: rtl/slot_phase_gen.sv
module slot_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ph_q,
  output logic ph_nxt
);
  assign ph_nxt = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_nxt;
  end

  // R1
  ph_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph_q != $past(ph_q)));
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import disp_arb_pkg::*;
#(
  parameter int             AW         = 24,
  parameter int             CW         = 8,
  parameter logic [AW-1:0]  DISP_LIMIT = 24'h200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_q,
  input  logic          as_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          dma_req,
  input  logic          dma_wr,
  input  logic [CW-1:0] dma_code,
  output owner_e        own_q,
  output owner_e        own_d,
  output logic          wr_d,
  output logic [CW-1:0] code_q,
  output logic          dtack_n_q
);
  localparam logic [CW-1:0] IDLE_CODE = {CW{1'b1}};

  logic          wr_q;
  logic [CW-1:0] code_d;
  logic          dtack_n_d;
  logic          armed_q, armed_d;
  logic          in_disp, cpu_wants, slot_end, mid_slot;

  assign in_disp   = (addr < DISP_LIMIT);
  assign cpu_wants = !as_n && armed_q && in_disp;
  assign slot_end  = ph_q;
  assign mid_slot  = !ph_q;

  always_comb begin
    own_d     = own_q;
    wr_d      = wr_q;
    code_d    = code_q;
    dtack_n_d = dtack_n_q;
    armed_d   = armed_q;
    if (slot_end) begin
      if (dma_req) begin
        own_d  = OWN_DMA;
        wr_d   = dma_wr;
        code_d = dma_code;
      end else if (cpu_wants) begin
        own_d  = OWN_CPU;
        wr_d   = !rd;
        code_d = IDLE_CODE;
      end else begin
        own_d  = OWN_IDLE;
        wr_d   = 1'b0;
        code_d = IDLE_CODE;
      end
    end
    if (as_n) begin
      dtack_n_d = 1'b1;
      armed_d   = 1'b1;
    end else if (mid_slot && armed_q && ((own_q == OWN_CPU) || !in_disp)) begin
      dtack_n_d = 1'b0;
      armed_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q     <= OWN_IDLE;
      wr_q      <= 1'b0;
      code_q    <= IDLE_CODE;
      dtack_n_q <= 1'b1;
      armed_q   <= 1'b0;
    end else begin
      own_q     <= own_d;
      wr_q      <= wr_d;
      code_q    <= code_d;
      dtack_n_q <= dtack_n_d;
      armed_q   <= armed_d;
    end
  end

  // R2
  ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n_q) |-> ph_q);

  // R3
  dma_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && dma_req) |=> (own_q == OWN_DMA));

  // R3
  own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_slot |=> $stable(own_q));

  // R5
  far_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !dma_req && !in_disp) |=> (own_q != OWN_CPU));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> dtack_n_q);

  // R8
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != OWN_DMA) |-> (code_q == IDLE_CODE));
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import disp_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ph_q,
  input  logic   ph_nxt,
  input  owner_e own_nxt,
  input  logic   wr_nxt,
  output logic   ras_n_q,
  output logic   cas_n_q,
  output logic   we_n_q,
  output logic   drv_en_q,
  output logic   gnt_cpu_q,
  output logic   gnt_dma_q
);
  logic busy_nxt;
  logic ras_n_d, cas_n_d, we_n_d, drv_en_d, gnt_cpu_d, gnt_dma_d;

  always_comb begin
    busy_nxt  = (own_nxt != OWN_IDLE);
    ras_n_d   = !busy_nxt;
    cas_n_d   = !(busy_nxt && ph_nxt);
    we_n_d    = !(busy_nxt && wr_nxt);
    gnt_cpu_d = (own_nxt == OWN_CPU);
    gnt_dma_d = (own_nxt == OWN_DMA);
    drv_en_d  = gnt_cpu_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n_q   <= 1'b1;
      cas_n_q   <= 1'b1;
      we_n_q    <= 1'b1;
      drv_en_q  <= 1'b0;
      gnt_cpu_q <= 1'b0;
      gnt_dma_q <= 1'b0;
    end else begin
      ras_n_q   <= ras_n_d;
      cas_n_q   <= cas_n_d;
      we_n_q    <= we_n_d;
      drv_en_q  <= drv_en_d;
      gnt_cpu_q <= gnt_cpu_d;
      gnt_dma_q <= gnt_dma_d;
    end
  end

  // R7
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_q |-> (!ras_n_q && ph_q));

  // R9
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en_q && gnt_dma_q));
endmodule

// File: rtl/disp_slot_arb.sv
module disp_slot_arb
  import disp_arb_pkg::*;
#(
  parameter int             AW         = 24,
  parameter int             CW         = 8,
  parameter logic [AW-1:0]  DISP_LIMIT = 24'h200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_as_n,
  input  logic          cpu_rw,
  input  logic [AW-1:0] cpu_addr,
  input  logic          dma_req,
  input  logic          dma_wr,
  input  logic [CW-1:0] dma_code,
  output logic          cpu_dtack_n,
  output logic          slot_phase,
  output logic          grant_cpu,
  output logic          grant_dma,
  output logic [CW-1:0] reg_code,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          disp_drv_en
);
  logic   ph_q, ph_nxt;
  owner_e own_q, own_d;
  logic   wr_d;

  slot_phase_gen u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph_q   (ph_q),
    .ph_nxt (ph_nxt)
  );

  slot_arbiter #(.AW(AW), .CW(CW), .DISP_LIMIT(DISP_LIMIT)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_q      (ph_q),
    .as_n      (cpu_as_n),
    .rd        (cpu_rw),
    .addr      (cpu_addr),
    .dma_req   (dma_req),
    .dma_wr    (dma_wr),
    .dma_code  (dma_code),
    .own_q     (own_q),
    .own_d     (own_d),
    .wr_d      (wr_d),
    .code_q    (reg_code),
    .dtack_n_q (cpu_dtack_n)
  );

  dram_strobe_gen u_dram (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_q      (ph_q),
    .ph_nxt    (ph_nxt),
    .own_nxt   (own_d),
    .wr_nxt    (wr_d),
    .ras_n_q   (ras_n),
    .cas_n_q   (cas_n),
    .we_n_q    (we_n),
    .drv_en_q  (disp_drv_en),
    .gnt_cpu_q (grant_cpu),
    .gnt_dma_q (grant_dma)
  );

  assign slot_phase = ph_q;

  // R9
  grant_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_cpu == (own_q == OWN_CPU)) && (grant_dma == (own_q == OWN_DMA)));
endmodule

// File: tb/disp_slot_arb_bench.sv
module disp_slot_arb_bench;
  localparam logic [23:0] LIM  = 24'h200000;
  localparam logic [7:0]  IDLE = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_as_n = 1'b1, cpu_rw = 1'b1;
  logic [23:0] cpu_addr = 24'h0;
  logic        dma_req = 1'b0, dma_wr = 1'b0;
  logic [7:0]  dma_code = 8'h00;
  logic        cpu_dtack_n, slot_phase, grant_cpu, grant_dma;
  logic [7:0]  reg_code;
  logic        ras_n, cas_n, we_n, disp_drv_en;

  int tests = 0, fails = 0;
  int dma_left = 0;
  bit dma_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  disp_slot_arb u_disp_slot_arb (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .dma_req(dma_req), .dma_wr(dma_wr),
    .dma_code(dma_code), .cpu_dtack_n(cpu_dtack_n), .slot_phase(slot_phase),
    .grant_cpu(grant_cpu), .grant_dma(grant_dma), .reg_code(reg_code),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .disp_drv_en(disp_drv_en)
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: owner 0 idle, 1 processor, 2 DMA
  int   m_ph, m_own, m_wr, m_dt, m_arm;
  logic [7:0] m_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_own <= 0; m_wr <= 0; m_code <= IDLE; m_dt <= 1; m_arm <= 0;
    end else begin
      m_ph <= 1 - m_ph;
      if (m_ph == 1) begin
        if (dma_req) begin m_own <= 2; m_wr <= int'(dma_wr); m_code <= dma_code; end
        else if (!cpu_as_n && m_arm == 1 && cpu_addr < LIM) begin
          m_own <= 1; m_wr <= int'(!cpu_rw); m_code <= IDLE;
        end else begin m_own <= 0; m_wr <= 0; m_code <= IDLE; end
      end
      if (cpu_as_n) begin m_dt <= 1; m_arm <= 1; end
      else if (m_ph == 0 && m_arm == 1 && (m_own == 1 || cpu_addr >= LIM)) begin
        m_dt <= 0; m_arm <= 0;
      end
    end
  end

  logic prev_dt = 1'b1;
  always @(negedge clk) begin
    string rt;
    rt = rst_n ? "" : " R10";
    chk({"R1 slot_phase", rt}, int'(slot_phase), m_ph);
    chk({"R2 R4 R5 R6 cpu_dtack_n", rt}, int'(cpu_dtack_n), m_dt);
    chk({"R3 grant_cpu", rt}, int'(grant_cpu), int'(m_own == 1));
    chk({"R3 grant_dma", rt}, int'(grant_dma), int'(m_own == 2));
    chk({"R8 reg_code", rt}, int'(reg_code), int'(m_code));
    chk({"R7 ras_n", rt}, int'(ras_n), int'(m_own == 0));
    chk({"R7 cas_n", rt}, int'(cas_n), int'(!(m_own != 0 && m_ph == 1)));
    chk({"R7 we_n", rt}, int'(we_n), int'(!(m_own != 0 && m_wr == 1)));
    chk({"R9 disp_drv_en", rt}, int'(disp_drv_en), int'(m_own == 1));
    chk("R9 no dual drive", int'(disp_drv_en && grant_dma), 0);
    if (prev_dt && !cpu_dtack_n) chk("R2 ack phase", int'(slot_phase), 1);
    prev_dt = cpu_dtack_n;
  end

  // DMA stimulus
  initial forever begin
    @(negedge clk); #1;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dma_code = dma_code + 8'd1;
    dma_wr   = lfsr[3];
    if (dma_left > 0) begin dma_req = 1'b1; dma_left--; end
    else dma_req = dma_rand ? lfsr[0] : 1'b0;
  end

  task automatic wait_phase(input logic p);
    do @(negedge clk); while (slot_phase != p);
  endtask

  task automatic cpu_access(input logic [23:0] a, input logic rd, input int hold,
                            input int exp_lat, input string tag);
    int lat;
    #1; cpu_addr = a; cpu_rw = rd; cpu_as_n = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (cpu_dtack_n && lat < 60);
    if (exp_lat > 0) chk({tag, " latency"}, lat, exp_lat);
    else if (exp_lat < 0) chk({tag, " waited past DMA"}, int'(lat >= -exp_lat), 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!dma_rand) chk("R6 no regrant while held", int'(grant_cpu), 0);
      chk("R6 ack held", int'(cpu_dtack_n), 0);
    end
    #1; cpu_as_n = 1'b1;
    @(negedge clk);
    chk("R6 ack released", int'(cpu_dtack_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset dtack", int'(cpu_dtack_n), 1);
    chk("R10 reset code", int'(reg_code), int'(IDLE));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4: display read and write in each starting phase, idle bus
    for (int p = 0; p < 2; p++) begin
      wait_phase(p[0]); cpu_access(24'h001234, 1'b1, 0, p ? 2 : 3, "R4 read");
      wait_phase(p[0]); cpu_access(24'h1FFFFF, 1'b0, 0, p ? 2 : 3, "R4 R7 write");
    end
    // R5: non-display on idle bus and under a DMA burst
    for (int p = 0; p < 2; p++) begin
      wait_phase(p[0]); cpu_access(24'h200000, 1'b1, 0, p ? 2 : 1, "R5 far idle");
      wait_phase(p[0]); dma_left = 12;
      cpu_access(24'hFF0000, 1'b0, 0, p ? 2 : 1, "R5 far during DMA");
      repeat (14) @(negedge clk);
    end
    // R3: display access stalled by a DMA burst
    for (int p = 0; p < 2; p++) begin
      wait_phase(p[0]); dma_left = 8;
      cpu_access(24'h000100, p[0], 0, -5, "R3 R4 behind DMA");
      repeat (10) @(negedge clk);
    end
    // R6: strobe held low after the acknowledge
    wait_phase(1'b0); cpu_access(24'h000040, 1'b1, 5, 3, "R6 held read");
    wait_phase(1'b1); cpu_access(24'h300000, 1'b1, 4, 2, "R5 R6 held far");
    // R8 R9: random DMA traffic with mixed accesses
    dma_rand = 1'b1;
    for (int k = 0; k < 60; k++) begin
      cpu_access((k % 3 == 0) ? 24'h250000 : 24'h000800 + 24'(k), k[0], k % 3, 0, "R8 mixed");
      @(negedge clk);
    end
    dma_rand = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset ras_n", int'(ras_n), 1);
    chk("R10 reset grant", int'(grant_cpu | grant_dma | disp_drv_en), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog got expired exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule